// File: doc/BRIEF.md
# Pipelined 3x3 Matrix Multiplier

This block multiplies a three-element input vector by a 3x3 matrix of programmable coefficients. It accepts a new vector every clock and returns three dot products every clock. It suits per-pixel work such as colour-space conversion. Each of the three outputs (X, Y, Z) has its own coefficient set, which holds one weight for each of the inputs A, B and C. The inputs are 12-bit signed samples. The coefficients are 10-bit signed fixed-point values with eight fractional bits. Each sum is rounded back to the 12-bit sample width.

A 2-bit write code stores a new coefficient set from three coefficient inputs. A vector presented in the same cycle as the write already uses the new values. Vectors still inside the pipeline keep the coefficients they entered with, so the matrix can be changed in the middle of a stream without corrupting results. The latency is fixed at five cycles. A valid flag travels alongside the data.

Top module: `mat3_mul`

## Requirements
- R1: An active-low asynchronous reset clears every pipeline stage and every stored coefficient. While it is held, and for five cycles after release, the outputs are zero and `outValid` is low. Until a set is written, that set gives zero.
- R2: `xOut` is derived from A·K1a + B·K1b + C·K1c using set 1. `yOut` uses set 2 in the same way, and `zOut` uses set 3.
- R3: Each sum is rounded by adding 128 and then shifting right arithmetically by 8 bits. The output is the low 12 bits of that result, so values out of range wrap.
- R4: A vector presented in cycle n gives its results in cycle n+5. A new result follows every cycle.
- R5: `outValid` in cycle n+5 equals `inValid` in cycle n.
- R6: `coefWe` selects the set to write: 01 writes set 1 (X), 10 writes set 2 (Y) and 11 writes set 3 (Z). `coefA`, `coefB` and `coefC` give the weights for inputs A, B and C respectively.
- R7: A vector presented in the same cycle as a write uses the newly written set. Vectors presented earlier keep their old coefficients, even while they are still in the pipeline.
- R8: When `coefWe` is 00, all stored coefficients hold, whatever is on the coefficient inputs.
- R9: Inputs are 12-bit two's complement integers. Coefficients are 10-bit two's complement values in which 256 represents 1.0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Marks the presented vector as meaningful |
| aIn | input | 12 | Input sample A |
| bIn | input | 12 | Input sample B |
| cIn | input | 12 | Input sample C |
| coefWe | input | 2 | Coefficient set write code |
| coefA | input | 10 | Weight applied to A in the written set |
| coefB | input | 10 | Weight applied to B in the written set |
| coefC | input | 10 | Weight applied to C in the written set |
| outValid | output | 1 | Valid flag, delayed five cycles |
| xOut | output | 12 | Rounded result for set 1 |
| yOut | output | 12 | Rounded result for set 2 |
| zOut | output | 12 | Rounded result for set 3 |

## Verification
The hardest case to reach is a coefficient write that arrives while older vectors are still in flight. Each of those vectors must keep the matrix it entered with, and the vector presented alongside the write must already see the new matrix. The stimulus streams vectors without a gap and issues random writes to random sets every few cycles. It therefore regularly places writes so that two or three different matrices are in the pipeline at once. Directed steps set exact rounding boundaries just above and below half an LSB, on both sides of zero, and force wrap-around with the largest weights.

// File: rtl/mat3_pkg.sv
package mat3_pkg;
  // number of input lanes, output lanes and coefficient sets
  localparam int NLANE = 3;
  // register stages from input capture to output register
  localparam int LAT = 5;

  typedef struct packed {
    logic [NLANE-1:0] wrSel;  // one-hot coefficient set write strobe
  } mat3Strobe_t;
endpackage

// File: rtl/mat3_ctrl.sv
module mat3_ctrl
  import mat3_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [1:0]  coefWe,
  output mat3Strobe_t strb,
  output logic        outValid
);
  localparam int CNTW = $clog2(LAT + 1);

  logic [LAT-1:0]  validPipe;
  logic [CNTW-1:0] sinceRst;

  // decode the write code into a one-hot set strobe
  always_comb begin
    strb = '0;
    case (coefWe)
      2'b01:   strb.wrSel[0] = 1'b1;
      2'b10:   strb.wrSel[1] = 1'b1;
      2'b11:   strb.wrSel[2] = 1'b1;
      default: strb.wrSel    = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validPipe <= '0;
      sinceRst  <= '0;
    end else begin
      validPipe <= {validPipe[LAT-2:0], inValid};
      if (sinceRst != CNTW'(LAT)) sinceRst <= sinceRst + 1'b1;
    end
  end

  assign outValid = validPipe[LAT-1];

  // R6: at most one set is written per cycle
  assert_one_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.wrSel));

  // R5: the valid flag emerges exactly LAT cycles after it entered
  assert_valid_delay_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == CNTW'(LAT)) |-> (outValid == $past(inValid, LAT)));

  // R1: reset holds the valid flag low
  always_ff @(posedge clk) begin
    if (!rstN) begin
      assert_reset_quiet_R1: assert (!outValid)
        else $error("outValid high during reset");
    end
  end
endmodule

// File: rtl/mat3_datapath.sv
module mat3_datapath
  import mat3_pkg::*;
#(
  parameter int DW   = 12,
  parameter int CW   = 10,
  parameter int FRAC = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mat3Strobe_t          strb,
  input  logic signed [DW-1:0] dIn [NLANE],
  input  logic signed [CW-1:0] kIn [NLANE],
  output logic signed [DW-1:0] res [NLANE]
);
  localparam int PW = DW + CW;               // one product
  localparam int SW = PW + $clog2(NLANE);    // sum of NLANE products
  localparam logic signed [SW-1:0] HALF = SW'(2 ** (FRAC - 1));

  logic signed [CW-1:0] bank   [NLANE][NLANE];  // [set][input]
  logic signed [DW-1:0] dataS1 [NLANE];
  logic signed [CW-1:0] coefS1 [NLANE][NLANE];
  logic signed [PW-1:0] prodS2 [NLANE][NLANE];
  logic signed [SW-1:0] pairS3 [NLANE];
  logic signed [PW-1:0] lastS3 [NLANE];
  logic signed [SW-1:0] sumS4  [NLANE];

  // stage 1: input sample capture
  for (genvar i = 0; i < NLANE; i++) begin : gIn
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) dataS1[i] <= '0;
      else       dataS1[i] <= dIn[i];
    end
  end

  for (genvar s = 0; s < NLANE; s++) begin : gSet
    for (genvar i = 0; i < NLANE; i++) begin : gTerm
      // coefficient store, coefficient copy riding with the data, product
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          bank[s][i]   <= '0;
          coefS1[s][i] <= '0;
          prodS2[s][i] <= '0;
        end else begin
          if (strb.wrSel[s]) bank[s][i] <= kIn[i];
          coefS1[s][i] <= strb.wrSel[s] ? kIn[i] : bank[s][i];
          prodS2[s][i] <= PW'(dataS1[i]) * PW'(coefS1[s][i]);
        end
      end

      // R8: with no strobe for this set, its stored weights hold
      assert_bank_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
        !strb.wrSel[s] |=> $stable(bank[s][i]));
    end

    // stages 3..5: two-level adder tree, then rounding into the output register
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pairS3[s] <= '0;
        lastS3[s] <= '0;
        sumS4[s]  <= '0;
        res[s]    <= '0;
      end else begin
        pairS3[s] <= SW'(prodS2[s][0]) + SW'(prodS2[s][1]);
        lastS3[s] <= prodS2[s][2];
        sumS4[s]  <= pairS3[s] + SW'(lastS3[s]);
        res[s]    <= DW'((sumS4[s] + HALF) >>> FRAC);
      end
    end
  end
endmodule

// File: rtl/mat3_mul.sv
module mat3_mul
  import mat3_pkg::*;
#(
  parameter int DW   = 12,
  parameter int CW   = 10,
  parameter int FRAC = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [DW-1:0] aIn,
  input  logic [DW-1:0] bIn,
  input  logic [DW-1:0] cIn,
  input  logic [1:0]    coefWe,
  input  logic [CW-1:0] coefA,
  input  logic [CW-1:0] coefB,
  input  logic [CW-1:0] coefC,
  output logic          outValid,
  output logic [DW-1:0] xOut,
  output logic [DW-1:0] yOut,
  output logic [DW-1:0] zOut
);
  localparam int CNTW = $clog2(LAT + 1);

  mat3Strobe_t          strb;
  logic signed [DW-1:0] dVec [NLANE];
  logic signed [CW-1:0] kVec [NLANE];
  logic signed [DW-1:0] rVec [NLANE];
  logic [CNTW-1:0]      warmCnt;

  assign dVec[0] = aIn;
  assign dVec[1] = bIn;
  assign dVec[2] = cIn;
  assign kVec[0] = coefA;
  assign kVec[1] = coefB;
  assign kVec[2] = coefC;

  mat3_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .coefWe  (coefWe),
    .strb    (strb),
    .outValid(outValid)
  );

  mat3_datapath #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_dp (
    .clk (clk),
    .rstN(rstN),
    .strb(strb),
    .dIn (dVec),
    .kIn (kVec),
    .res (rVec)
  );

  assign xOut = rVec[0];
  assign yOut = rVec[1];
  assign zOut = rVec[2];

  // cycles since reset release, saturating, so the checks below only look back
  // over cycles that lie after reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) warmCnt <= '0;
    else if (warmCnt != CNTW'(LAT)) warmCnt <= warmCnt + 1'b1;
  end

  // R2/R4: an all-zero vector yields all-zero results LAT cycles later,
  // whatever coefficients it met
  assert_zero_in_zero_out_R2: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt == CNTW'(LAT) && $past(aIn, LAT) == '0 && $past(bIn, LAT) == '0
     && $past(cIn, LAT) == '0) |-> (xOut == '0 && yOut == '0 && zOut == '0));

  // R4: results change only as a consequence of data that entered earlier
  assert_quiet_pipe_R4: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt != CNTW'(LAT)) |-> (xOut == '0 && yOut == '0 && zOut == '0));
endmodule

// File: tb/sim_mat3_mul.sv
`timescale 1ns/1ps
module sim_mat3_mul;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [11:0] aIn = '0, bIn = '0, cIn = '0;
  logic [1:0]  coefWe = '0;
  logic [9:0]  coefA = '0, coefB = '0, coefC = '0;
  logic        outValid;
  logic [11:0] xOut, yOut, zOut;

  int checks = 0;
  int errs   = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  logic [9:0]  bk [3][3];          // model of stored sets [set][input]
  logic [11:0] ex [8], ey [8], ez [8];
  bit          ev [8];
  string       tg [8];

  always #10 clk = ~clk;  // 50 MHz

  mat3_mul u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .aIn(aIn), .bIn(bIn), .cIn(cIn),
    .coefWe(coefWe), .coefA(coefA), .coefB(coefB), .coefC(coefC),
    .outValid(outValid), .xOut(xOut), .yOut(yOut), .zOut(zOut)
  );

  // R2/R3/R9: signed dot product, add half, arithmetic shift by 8, keep 12 bits
  function automatic logic [11:0] dot3(input logic [11:0] a, b, c,
                                       input logic [9:0] ka, kb, kc);
    longint sa, sb, sc, wa, wb, wc, sum, r;
    sa = longint'($signed(a)); sb = longint'($signed(b)); sc = longint'($signed(c));
    wa = longint'($signed(ka)); wb = longint'($signed(kb)); wc = longint'($signed(kc));
    sum = sa * wa + sb * wb + sc * wc;
    r = (sum + 128) >>> 8;
    return r[11:0];
  endfunction

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s cycle %0d: act=%h exp=%h", req, cyc, act, exp);
    end
  endtask

  task automatic checkNow();
    int k;
    k = cyc % 8;
    chk(tg[k], xOut, ex[k]);
    chk(tg[k], yOut, ey[k]);
    chk(tg[k], zOut, ez[k]);
    chk("R5", {11'd0, outValid}, {11'd0, ev[k]});
  endtask

  task automatic step(input bit v, input int a, input int b, input int c,
                      input logic [1:0] we, input int ka, input int kb, input int kc,
                      input string tag);
    int k;
    @(negedge clk);
    checkNow();
    inValid = v;
    aIn = a[11:0]; bIn = b[11:0]; cIn = c[11:0];
    coefWe = we;
    coefA = ka[9:0]; coefB = kb[9:0]; coefC = kc[9:0];
    if (we != 2'b00) begin  // R6/R7: written set applies to this vector too
      bk[int'(we) - 1][0] = coefA;
      bk[int'(we) - 1][1] = coefB;
      bk[int'(we) - 1][2] = coefC;
    end
    k = (cyc + 5) % 8;
    ex[k] = dot3(aIn, bIn, cIn, bk[0][0], bk[0][1], bk[0][2]);
    ey[k] = dot3(aIn, bIn, cIn, bk[1][0], bk[1][1], bk[1][2]);
    ez[k] = dot3(aIn, bIn, cIn, bk[2][0], bk[2][1], bk[2][2]);
    ev[k] = v;
    tg[k] = tag;
    cyc++;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    inValid = 1'b0; coefWe = 2'b00;
    aIn = 12'h5A5; bIn = 12'h3C3; cIn = 12'h7FF;
    coefA = 10'h1FF; coefB = 10'h155; coefC = 10'h0AA;
    @(negedge clk);
    // R1: everything clear while reset is held
    chk("R1", xOut, 12'h000);
    chk("R1", yOut, 12'h000);
    chk("R1", zOut, 12'h000);
    chk("R1", {11'd0, outValid}, 12'h000);
    for (int s = 0; s < 3; s++)
      for (int i = 0; i < 3; i++) bk[s][i] = '0;
    for (int k = 0; k < 8; k++) begin
      ex[k] = '0; ey[k] = '0; ez[k] = '0; ev[k] = 1'b0; tg[k] = "R1";
    end
    cyc = 0;
    rstN = 1'b1;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL R4 watchdog expired: act=running exp=finished");
      finishRun();
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    doReset();

    // R1: stored sets were cleared, so data alone gives zero
    step(1, 12'h7FF, 12'h123, 12'h800, 2'b00, 0, 0, 0, "R1");
    step(1, 12'h456, 12'hFFF, 12'h001, 2'b00, 0, 0, 0, "R1");
    step(0, 12'h100, 12'h200, 12'h300, 2'b00, 0, 0, 0, "R1");

    // R2/R6: near-identity permutation, 256 = 1.0
    step(1, 100, 200, 300, 2'b01, 256, 0, 0, "R6");
    step(1, 100, 200, 300, 2'b10, 0, 256, 0, "R6");
    step(1, 100, 200, 300, 2'b11, 0, 0, 256, "R6");
    step(1, 12'h7FF, 12'h800, 12'hABC, 2'b00, 0, 0, 0, "R2");
    step(1, 17, 12'hFF0, 5, 2'b00, 0, 0, 0, "R2");

    // R7: a write in the middle of the stream; older vectors keep old weights
    step(1, 50, 60, 70, 2'b01, 128, 128, 0, "R7");
    step(1, 50, 60, 70, 2'b00, 0, 0, 0, "R7");
    step(1, 50, 60, 70, 2'b10, 12'h3FF, 0, 0, "R7");

    // R8: no-write code with noisy coefficient inputs
    step(1, 300, 400, 500, 2'b00, 12'h1FF, 12'h200, 12'h0F0, "R8");
    step(1, 301, 401, 501, 2'b00, 12'h2AA, 12'h155, 12'h3FF, "R8");

    // R3: rounding boundaries with a weight of 1/256 on A only
    step(0, 0, 0, 0, 2'b01, 1, 0, 0, "R3");
    step(0, 0, 0, 0, 2'b10, 1, 0, 0, "R3");
    step(0, 0, 0, 0, 2'b11, 1, 0, 0, "R3");
    step(1, 128, 0, 0, 2'b00, 0, 0, 0, "R3");    // -> 1
    step(1, 127, 0, 0, 2'b00, 0, 0, 0, "R3");    // -> 0
    step(1, -128, 0, 0, 2'b00, 0, 0, 0, "R3");   // -> 0
    step(1, -129, 0, 0, 2'b00, 0, 0, 0, "R3");   // -> FFF
    step(1, 383, 0, 0, 2'b00, 0, 0, 0, "R3");    // -> 1
    step(1, 384, 0, 0, 2'b00, 0, 0, 0, "R3");    // -> 2

    // R3: wrap-around with the extreme weights
    step(1, 2047, 2047, 2047, 2'b01, 511, 511, 511, "R3");
    step(1, -2048, -2048, -2048, 2'b10, -512, -512, -512, "R3");
    step(1, -2048, 2047, -2048, 2'b11, 511, -512, 511, "R3");

    // R9: negative samples against negative weights
    step(1, -5, -1000, -2048, 2'b01, -3, -300, -1, "R9");
    step(1, -7, 12, -2000, 2'b00, 0, 0, 0, "R9");

    // R4: continuous random stream, occasional writes to random sets
    for (int n = 0; n < 400; n++) begin
      logic [1:0] we;
      we = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      step(bit'($urandom_range(0, 1)),
           int'($urandom_range(0, 4095)), int'($urandom_range(0, 4095)),
           int'($urandom_range(0, 4095)), we,
           int'($urandom_range(0, 1023)), int'($urandom_range(0, 1023)),
           int'($urandom_range(0, 1023)), "R4");
    end

    // R1: reset in the middle of a stream clears sets and pipeline
    doReset();
    step(1, 999, 888, 777, 2'b00, 0, 0, 0, "R1");
    step(1, 999, 888, 777, 2'b01, 256, 256, 256, "R2");
    for (int n = 0; n < 7; n++)
      step(0, 0, 0, 0, 2'b00, 0, 0, 0, "R4");

    done = 1'b1;
    finishRun();
  end
endmodule